// File: doc/BRIEF.md
# Ordered Power Rail Sequencer

This block drives the enable lines of a fixed set of power rails. When the power request is raised it turns the rails on one at a time, from index 0 upward. Before it moves on, each rail must report power good within a qualification window, and a programmable pause is then inserted. When the request is dropped, the rails are turned off one per cycle from the highest enabled index downward, which is the reverse of the power-up order.

Faults also shut the rails down in reverse order. A fault is one of the following:
- a rail that never qualifies;
- an overvoltage flag on an enabled rail;
- an undervoltage flag on an enabled rail;
- a qualified rail losing power good while the block is fully on.

After a fault shutdown the block waits a programmable discharge time. It then either restarts the sequence, within a bounded number of retries, or locks out until the request is withdrawn. The block needs only power-good inputs. The overvoltage and undervoltage flags are optional, and each has its own programmable response.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst_n` is low, `rail_en` is all zero, `seq_state` is 0 (idle) and `retry_count` is 0.
- R2: On power-up the rails are enabled one at a time in ascending index order. Rail i+1 is never enabled before rail i has been seen power good.
- R3: Suppose `pgood[i]` is high at clock edge t, while rail i (not the last rail) is waiting to qualify. Then `rail_en[i+1]` rises at edge t + `delay_cycles` + 2.
- R4: Once the last rail qualifies, `seq_state` reads 4 (fully on) and every bit of `rail_en` is 1. The state codes are: 0 idle, 1 enable, 2 qualify, 3 delay, 4 on, 5 shutdown, 6 discharge, 7 lockout.
- R5: Dropping `pwr_req` while fully on clears the enables one per cycle from the highest index to index 0. The block then returns to idle with no discharge wait.
- R6: Dropping `pwr_req` part-way through power-up disables only the rails already enabled, highest first, and then returns to idle.
- R7: If a rail does not show power good within `qual_cycles`+1 clock edges of being enabled, every enabled rail is shut down in reverse order. This shutdown is eligible for a retry.
- R8: After a fault shutdown, rail 0 is re-enabled exactly `discharge_cycles`+2 cycles after it was disabled, provided a retry is allowed.
- R9: Retries happen only while `retry_count` < `retry_limit`, and each retry increments `retry_count`. Otherwise the block enters lockout (7) with all rails off.
- R10: Lockout holds every rail off for as long as `pwr_req` stays high. Dropping `pwr_req` returns the block to idle with `retry_count` cleared, and a new request powers up normally.
- R11: `ov_resp` and `uv_resp` select the response to a flag on an enabled rail. The values are 0 ignore, 1 shutdown without retry (lockout after discharge), 2 shutdown with retry, and 3 the same as 1.
- R12: Loss of `pgood` on an enabled rail while fully on counts as an undervoltage event under `uv_resp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_req | input | 1 | Request to power the rails |
| pgood | input | N_RAILS | Power-good per rail |
| ov_flag | input | N_RAILS | Overvoltage event per rail |
| uv_flag | input | N_RAILS | Undervoltage event per rail |
| qual_cycles | input | TW | Qualification window length |
| delay_cycles | input | TW | Pause between rails |
| discharge_cycles | input | TW | Wait after a fault shutdown |
| retry_limit | input | RW | Maximum automatic retries |
| ov_resp | input | 2 | Overvoltage response code |
| uv_resp | input | 2 | Undervoltage response code |
| rail_en | output | N_RAILS | Rail enables |
| seq_state | output | 3 | Current sequencer state code |
| retry_count | output | RW | Retries used since last idle |

## Verification
A corrupted rail index or state register shows at the ports within one cycle. It appears as an enable edge on the wrong rail or in the wrong direction, and the scoreboard flags that edge as it happens. A timer that miscounts moves an enable edge away from the cycle that the configured delay or discharge time predicts, and the bench measures those gaps exactly. A faulty retry counter or fault latch shows up as an extra or missing power-up sequence, or as lockout being reached after the wrong number of attempts.

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int N_RAILS = 4,
  parameter int TW      = 16,
  parameter int RW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_req,
  input  logic [N_RAILS-1:0] pgood,
  input  logic [N_RAILS-1:0] ov_flag,
  input  logic [N_RAILS-1:0] uv_flag,
  input  logic [TW-1:0]      qual_cycles,
  input  logic [TW-1:0]      delay_cycles,
  input  logic [TW-1:0]      discharge_cycles,
  input  logic [RW-1:0]      retry_limit,
  input  logic [1:0]         ov_resp,
  input  logic [1:0]         uv_resp,
  output logic [N_RAILS-1:0] rail_en,
  output logic [2:0]         seq_state,
  output logic [RW-1:0]      retry_count
);
  localparam int IW = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_RAILS - 1);
  localparam logic [2:0] S_OFF = 3'd0, S_EN = 3'd1, S_QUAL = 3'd2, S_DLY = 3'd3,
                         S_ON = 3'd4, S_DOWN = 3'd5, S_DIS = 3'd6, S_LOCK = 3'd7;

  logic [2:0]    st;
  logic [IW-1:0] idx;
  logic [TW-1:0] tmr;
  logic          fault_pend, retry_ok;
  logic          ov_hit, uv_hit, trip, trip_retry;

  assign ov_hit     = |(ov_flag & rail_en);
  assign uv_hit     = |(uv_flag & rail_en) | ((st == S_ON) & |(rail_en & ~pgood));
  assign trip       = (ov_hit && ov_resp != 2'd0) || (uv_hit && uv_resp != 2'd0);
  assign trip_retry = !((ov_hit && ov_resp[0]) || (uv_hit && uv_resp[0]));
  assign seq_state  = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_OFF;
      idx         <= '0;
      tmr         <= '0;
      rail_en     <= '0;
      retry_count <= '0;
      fault_pend  <= 1'b0;
      retry_ok    <= 1'b0;
    end else begin
      case (st)
        S_OFF: begin
          idx        <= '0;
          fault_pend <= 1'b0;
          if (pwr_req) st <= S_EN;
        end
        S_EN: begin
          rail_en[idx] <= 1'b1;
          tmr          <= '0;
          st           <= S_QUAL;
        end
        S_QUAL: begin
          if (!pwr_req) st <= S_DOWN;
          else if (trip) begin
            st <= S_DOWN; fault_pend <= 1'b1; retry_ok <= trip_retry;
          end else if (pgood[idx]) begin
            tmr <= '0;
            st  <= (idx == LAST) ? S_ON : S_DLY;
          end else if (tmr == qual_cycles) begin
            st <= S_DOWN; fault_pend <= 1'b1; retry_ok <= 1'b1;
          end else tmr <= tmr + 1'b1;
        end
        S_DLY: begin
          if (!pwr_req) st <= S_DOWN;
          else if (trip) begin
            st <= S_DOWN; fault_pend <= 1'b1; retry_ok <= trip_retry;
          end else if (tmr == delay_cycles) begin
            idx <= idx + 1'b1;
            st  <= S_EN;
          end else tmr <= tmr + 1'b1;
        end
        S_ON: begin
          if (!pwr_req) st <= S_DOWN;
          else if (trip) begin
            st <= S_DOWN; fault_pend <= 1'b1; retry_ok <= trip_retry;
          end
        end
        S_DOWN: begin
          rail_en[idx] <= 1'b0;
          if (idx == '0) begin
            tmr <= '0;
            if (fault_pend) st <= S_DIS;
            else begin
              st <= S_OFF; retry_count <= '0;
            end
          end else idx <= idx - 1'b1;
        end
        S_DIS: begin
          if (!pwr_req) begin
            st <= S_OFF; retry_count <= '0;
          end else if (tmr == discharge_cycles) begin
            fault_pend <= 1'b0;
            if (retry_ok && retry_count < retry_limit) begin
              retry_count <= retry_count + 1'b1;
              idx         <= '0;
              st          <= S_EN;
            end else st <= S_LOCK;
          end else tmr <= tmr + 1'b1;
        end
        default: begin
          if (!pwr_req) begin
            st <= S_OFF; retry_count <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk #(
  parameter int N_RAILS = 4,
  parameter int RW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pwr_req,
  input logic [N_RAILS-1:0] rail_en,
  input logic [2:0]         seq_state,
  input logic [RW-1:0]      retry_count,
  input logic [RW-1:0]      retry_limit
);
  p_thermometer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en & N_RAILS'(rail_en + 1'b1)) == '0);
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_en ^ $past(rail_en)) <= 1);
  p_on_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 3'd4 |-> &rail_en);
  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 3'd0 |-> (rail_en == '0 && retry_count == '0));
  p_lock_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state == 3'd7 |-> rail_en == '0);
  p_retry_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_count <= retry_limit);
  p_lock_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd7 && !pwr_req) |=> seq_state == 3'd0);
endmodule

bind rail_sequencer rail_sequencer_chk #(.N_RAILS(N_RAILS), .RW(RW)) u_chk (.*);

// File: tb/rail_sequencer_bench.sv
module rail_sequencer_bench;
  localparam int N = 4, TW = 16, RW = 3;
  localparam int Q = 10, D = 3, DIS = 6;

  logic clk = 0, rst_n = 0, pwr_req = 0;
  logic [N-1:0] pgood, ov_flag = '0, uv_flag = '0, stuck = '0, drop = '0;
  logic [N-1:0] pg_model = '0, prev = '0;
  logic [TW-1:0] qual_cycles = TW'(Q), delay_cycles = TW'(D), discharge_cycles = TW'(DIS);
  logic [RW-1:0] retry_limit = RW'(2);
  logic [1:0] ov_resp = 2'd0, uv_resp = 2'd0;
  logic [N-1:0] rail_en;
  logic [2:0] seq_state;
  logic [RW-1:0] retry_count;

  int checks = 0, fails = 0, cyc = 0, got = 0, e = 0;
  int on_cyc[N], off_cyc[N];
  int exp_q[$];
  string cur_req = "R1";
  bit done = 0;

  rail_sequencer #(.N_RAILS(N), .TW(TW), .RW(RW)) u_rail_sequencer (.*);

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    pg_model <= rail_en & ~stuck & ~drop;
  end
  assign pgood = pg_model;

  // monitor: pops the expected enable edges and compares them
  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < N; i++) if (rail_en[i] !== prev[i]) begin
      got = (rail_en[i] ? 100 : 0) + i;
      if (rail_en[i]) on_cyc[i] = cyc; else off_cyc[i] = cyc;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s scoreboard: act=%0d exp=none", cur_req, got);
      end else begin
        e = exp_q.pop_front();
        if (e != got) begin
          fails++;
          $display("FAIL %s scoreboard: act=%0d exp=%0d", cur_req, got, e);
        end
      end
    end
    prev = rail_en;
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic push_up(int top);
    for (int i = 0; i <= top; i++) exp_q.push_back(100 + i);
  endtask

  task automatic push_down(int top);
    for (int i = top; i >= 0; i--) exp_q.push_back(i);
  endtask

  task automatic wait_state(int s, int lim);
    for (int n = 0; n < lim && seq_state != 3'(s); n++) @(negedge clk);
  endtask

  task automatic drain(string r);
    for (int n = 0; n < 300 && exp_q.size() != 0; n++) @(negedge clk);
    chk(r, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rail_en, 0); chk("R1", seq_state, 0); chk("R1", retry_count, 0);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R2"; push_up(N - 1); pwr_req = 1;
    wait_state(4, 300);
    chk("R4", seq_state, 4); chk("R4", rail_en, 15); drain("R2");
    chk("R3", on_cyc[1] - on_cyc[0], D + 4);
    chk("R3", on_cyc[3] - on_cyc[2], D + 4);

    cur_req = "R11"; ov_flag = 4'b0010;
    repeat (20) @(negedge clk);
    chk("R11", seq_state, 4); chk("R11", rail_en, 15);
    ov_flag = '0;

    cur_req = "R12"; drop = 4'b0100;
    repeat (10) @(negedge clk);
    chk("R12", seq_state, 4); chk("R12", rail_en, 15);
    drop = '0; repeat (3) @(negedge clk);

    uv_resp = 2'd2; push_down(N - 1); push_up(N - 1); drop = 4'b0001;
    repeat (3) @(negedge clk);
    drop = '0;
    drain("R12"); wait_state(4, 300);
    chk("R12", seq_state, 4); chk("R9", retry_count, 1);
    chk("R8", on_cyc[0] - off_cyc[0], DIS + 2);

    cur_req = "R11"; ov_resp = 2'd1; push_down(N - 1); ov_flag = 4'b0010;
    repeat (2) @(negedge clk);
    ov_flag = '0;
    wait_state(7, 300); drain("R11");
    chk("R11", seq_state, 7); chk("R11", retry_count, 1); chk("R11", rail_en, 0);
    cur_req = "R10"; pwr_req = 0;
    repeat (2) @(negedge clk);
    chk("R10", seq_state, 0); chk("R10", retry_count, 0);
    push_up(N - 1); pwr_req = 1;
    wait_state(4, 300); drain("R10"); chk("R10", seq_state, 4);

    cur_req = "R5"; push_down(N - 1); pwr_req = 0;
    wait_state(0, 100); drain("R5");
    chk("R5", rail_en, 0); chk("R5", off_cyc[0] - off_cyc[3], 3);

    cur_req = "R6"; stuck = 4'b0010; push_up(1); push_down(1); pwr_req = 1;
    for (int n = 0; n < 100 && rail_en != 4'b0011; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    pwr_req = 0;
    wait_state(0, 100); drain("R6"); chk("R6", seq_state, 0); chk("R6", rail_en, 0);
    stuck = '0; @(negedge clk);

    cur_req = "R7"; stuck = 4'b0100;
    for (int k = 0; k < 3; k++) begin push_up(2); push_down(2); end
    pwr_req = 1;
    wait_state(7, 2000); drain("R7");
    chk("R9", seq_state, 7); chk("R9", retry_count, 2); chk("R9", rail_en, 0);
    cur_req = "R10";
    repeat (30) @(negedge clk);
    chk("R10", seq_state, 7); chk("R10", rail_en, 0);
    stuck = '0; pwr_req = 0;
    repeat (3) @(negedge clk);
    chk("R10", seq_state, 0); chk("R10", retry_count, 0);
    push_up(N - 1); pwr_req = 1;
    wait_state(4, 300); drain("R10"); chk("R10", rail_en, 15);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule